// File: doc/BRIEF.md
# Value-to-Word Stream Serializer

The block takes one flat value of `VALUE_W` bits from a parallel input and sends it out as a run of `WORD_W`-bit words on a streaming output. Both sides use a valid/ready handshake. Words go out least-significant first, with no gaps between the bits of the value. A value therefore needs `ceil(VALUE_W / WORD_W)` words. Changing `WORD_W` only moves the word boundaries; the bit layout stays the same.

Along with each value, the caller supplies a flag. The flag decides whether the final word of that value is marked as the end of a packet. When `WORD_W` does not divide `VALUE_W` evenly, the final word holds only the top bits that remain, and its unused upper bits are zero. When `WORD_W` is at least `VALUE_W`, the whole value goes out as one zero-extended word.

The input side accepts a new value only when the previous one has been fully drained. There is one idle cycle between values.

Top module: `word_serializer`

## Requirements
- R1: Word k of a value (counting from 0) carries value bits [(k+1)*WORD_W-1 : k*WORD_W], so word 0 holds the lowest WORD_W bits.
- R2: Exactly ceil(VALUE_W/WORD_W) words are accepted downstream per value. After the last of them is accepted, out_valid is low and in_ready is high in the following cycle.
- R3: When VALUE_W is not a multiple of WORD_W, the final word carries the remaining high bits of the value in its low positions, and its other bits are 0.
- R4: out_last is 1 only on the final word of a value, and only if in_last was 1 when that value was accepted. Otherwise out_last is 0.
- R5: A value and its in_last flag are captured on a clock edge where in_valid and in_ready are both 1. The output word appears (out_valid = 1) in the next cycle. in_ready then stays 0 until the final word is accepted, and in_valid asserted during that time has no effect on the words sent.
- R6: While out_valid is 1 and out_ready is 0, out_data, out_last and out_valid keep their values into the next cycle.
- R7: When WORD_W >= VALUE_W, each value is sent as a single word holding the value zero-extended to WORD_W bits.
- R8: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input value is present |
| in_ready | output | 1 | Block can accept a value |
| in_data | input | VALUE_W | Flat value to serialize |
| in_last | input | 1 | Mark this value's final word as end of packet |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | WORD_W | Output word |
| out_last | output | 1 | End-of-packet marker on the final word |

## Verification
The bench builds two instances. The first has VALUE_W = 40 and WORD_W = 16. This gives three words per value and a final word with eight padding bits, so slicing, counting, zero padding and stalls mid-value can all be checked. The second has VALUE_W = 8 and WORD_W = 16. It takes the single-word, zero-extended path that the generate selects when one word holds the whole value. Stimulus mixes both settings of the end-of-packet flag, output stalls on chosen words, and a new input offered while a value is still draining.

// File: rtl/word_serializer_pkg.sv
package word_serializer_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new value
    logic advance;  // current word accepted, move to next
  } serStrobes_t;

  function automatic int wordsFor(input int valueW, input int wordW);
    return (valueW + wordW - 1) / wordW;
  endfunction

endpackage

// File: rtl/word_serializer_ctrl.sv
module word_serializer_ctrl
  import word_serializer_pkg::*;
#(
  parameter int NUM_WORDS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output logic        outLast,
  output serStrobes_t strobes
);

  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic             busy;
  logic             lastReq;
  logic [IDX_W-1:0] wordIdx;
  logic             atFinal;

  assign atFinal         = (wordIdx == LAST_IDX);
  assign inReady         = !busy;
  assign outValid        = busy;
  assign outLast         = busy && lastReq && atFinal;
  assign strobes.load    = inValid && !busy;
  assign strobes.advance = busy && outReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      lastReq <= 1'b0;
      wordIdx <= '0;
    end else if (strobes.load) begin
      busy    <= 1'b1;
      lastReq <= inLast;
      wordIdx <= '0;
    end else if (strobes.advance) begin
      if (atFinal) begin
        busy    <= 1'b0;
        wordIdx <= '0;
      end else begin
        wordIdx <= wordIdx + 1'b1;
      end
    end
  end

  // R5: no new value is taken while words are still pending
  p_busy_blocks_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !inReady);

  // R6: valid and last hold during a stall
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outLast)));

  // R4: end marker never precedes acceptance of a non-final word path
  p_last_ends_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (outLast && outReady) |=> !outValid);

endmodule

// File: rtl/word_serializer_dp.sv
module word_serializer_dp
  import word_serializer_pkg::*;
#(
  parameter int VALUE_W = 40,
  parameter int WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  serStrobes_t        strobes,
  input  logic [VALUE_W-1:0] inData,
  output logic [WORD_W-1:0]  outData
);

  localparam int NUM_WORDS = wordsFor(VALUE_W, WORD_W);
  localparam int PAD_W     = NUM_WORDS * WORD_W;

  logic [PAD_W-1:0] shiftReg;

  assign outData = shiftReg[WORD_W-1:0];

  generate
    if (NUM_WORDS > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              shiftReg <= '0;
        else if (strobes.load)   shiftReg <= PAD_W'(inData);
        else if (strobes.advance)
          shiftReg <= {{WORD_W{1'b0}}, shiftReg[PAD_W-1:WORD_W]};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            shiftReg <= '0;
        else if (strobes.load) shiftReg <= PAD_W'(inData);
      end
    end
  endgenerate

endmodule

// File: rtl/word_serializer.sv
module word_serializer
  import word_serializer_pkg::*;
#(
  parameter int VALUE_W = 40,
  parameter int WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [VALUE_W-1:0] in_data,
  input  logic               in_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data,
  output logic               out_last
);

  localparam int NUM_WORDS = wordsFor(VALUE_W, WORD_W);
  localparam int REM_BITS  = VALUE_W - (NUM_WORDS - 1) * WORD_W;
  localparam int CNT_W     = $clog2(NUM_WORDS + 1) + 1;

  serStrobes_t strobes;

  word_serializer_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (in_valid),
    .inLast   (in_last),
    .outReady (out_ready),
    .inReady  (in_ready),
    .outValid (out_valid),
    .outLast  (out_last),
    .strobes  (strobes)
  );

  word_serializer_dp #(.VALUE_W(VALUE_W), .WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .inData  (in_data),
    .outData (out_data)
  );

  // Checker: words accepted since the last capture
  logic [CNT_W-1:0] beatCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      beatCnt <= '0;
    else if (in_valid && in_ready)   beatCnt <= '0;
    else if (out_valid && out_ready) beatCnt <= beatCnt + 1'b1;
  end

  // R2: input reopens only after exactly NUM_WORDS words
  p_word_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (beatCnt == CNT_W'(NUM_WORDS)));

  // R4: marker only on the final word
  p_last_on_final_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (beatCnt == CNT_W'(NUM_WORDS - 1)));

  // R6: data holds during a stall
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  // R5: output appears the cycle after capture
  p_capture_to_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  generate
    if (REM_BITS < WORD_W) begin : g_pad_chk
      // R3: unused bits of the final word are zero
      p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && beatCnt == CNT_W'(NUM_WORDS - 1))
          |-> (out_data[WORD_W-1:REM_BITS] == '0));
    end
  endgenerate

endmodule

// File: tb/word_serializer_bench.sv
module word_serializer_bench;

  localparam int B  = 40;
  localparam int W  = 16;
  localparam int N  = 3;
  localparam int B2 = 8;
  localparam int W2 = 16;
  localparam int NV = 5;

  localparam logic [B-1:0] VEC_DATA [NV] = '{
    40'hA5_1234_5678, 40'hFF_FFFF_FFFF, 40'h00_0000_0001,
    40'h3C_C3C3_0F0F, 40'h80_0001_8000};
  localparam logic VEC_LAST [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [N-1:0] VEC_STALL [NV] = '{3'b000, 3'b010, 3'b101, 3'b111, 3'b000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         inValid = 1'b0, inLast = 1'b0, outReady = 1'b0;
  logic [B-1:0] inData = '0;
  logic         inReady, outValid, outLast;
  logic [W-1:0] outData;

  logic          inValid2 = 1'b0, inLast2 = 1'b0, outReady2 = 1'b0;
  logic [B2-1:0] inData2 = '0;
  logic          inReady2, outValid2, outLast2;
  logic [W2-1:0] outData2;

  word_serializer #(.VALUE_W(B), .WORD_W(W)) u_word_serializer (
    .clk(clk), .rst_n(rst_n), .in_valid(inValid), .in_ready(inReady),
    .in_data(inData), .in_last(inLast), .out_valid(outValid),
    .out_ready(outReady), .out_data(outData), .out_last(outLast));

  word_serializer #(.VALUE_W(B2), .WORD_W(W2)) u_word_serializer_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(inValid2), .in_ready(inReady2),
    .in_data(inData2), .in_last(inLast2), .out_valid(outValid2),
    .out_ready(outReady2), .out_data(outData2), .out_last(outLast2));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expWord(input logic [B-1:0] v, input int k);
    logic [N*W-1:0] p;
    p = (N*W)'(v);
    return W'(p >> (k*W));
  endfunction

  // Send one value and drain its words; optionally poke input while busy
  task automatic runValue(input logic [B-1:0] v, input logic t,
                          input logic [N-1:0] stall, input logic poke);
    @(negedge clk);
    chk("R5 in_ready idle", 64'(inReady), 64'd1);
    inData = v; inLast = t; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R5 out_valid after capture", 64'(outValid), 64'd1);
    chk("R5 in_ready low while busy", 64'(inReady), 64'd0);
    for (int k = 0; k < N; k++) begin
      if (stall[k] || (poke && k == 0)) begin
        outReady = 1'b0;
        if (poke && k == 0) begin
          inData = ~v; inLast = ~t; inValid = 1'b1;
        end
        @(negedge clk);
        inValid = 1'b0;
        chk("R6 valid held", 64'(outValid), 64'd1);
        chk("R6 data held", 64'(outData), 64'(expWord(v, k)));
      end
      outReady = 1'b1;
      chk("R1 word data", 64'(outData), 64'(expWord(v, k)));
      chk("R4 last flag", 64'(outLast), 64'((k == N-1) && t));
      if (k == N-1)
        chk("R3 pad bits zero", 64'(outData[W-1:8]), 64'd0);
      @(negedge clk);
    end
    outReady = 1'b0;
    chk("R2 no extra word", 64'(outValid), 64'd0);
    chk("R2 input reopened", 64'(inReady), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 out_valid reset", 64'(outValid), 64'd0);
    chk("R8 in_ready reset", 64'(inReady), 64'd1);
    chk("R8 wide out_valid reset", 64'(outValid2), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      runValue(VEC_DATA[i], VEC_LAST[i], VEC_STALL[i], 1'b0);

    // R5: input offered during drain must not disturb words
    runValue(40'h12_3456_789A, 1'b1, 3'b000, 1'b1);

    // R7: single zero-extended word on the wide instance
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      inData2 = (j == 0) ? 8'hC7 : 8'hFF; inLast2 = (j == 0); inValid2 = 1'b1;
      @(negedge clk);
      inValid2 = 1'b0;
      outReady2 = 1'b1;
      chk("R7 single word valid", 64'(outValid2), 64'd1);
      chk("R7 zero-extended word", 64'(outData2), (j == 0) ? 64'h00C7 : 64'h00FF);
      chk("R4 wide last flag", 64'(outLast2), 64'(j == 0));
      @(negedge clk);
      outReady2 = 1'b0;
      chk("R2 wide one word only", 64'(outValid2), 64'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule